// File: doc/BRIEF.md
# Packed Byte Add/Subtract Unit with Flag-Driven Select

This block treats each 32-bit operand as four separate 8-bit lanes and applies one arithmetic operation to all lanes at once. Each lane adds or subtracts, reads its operands as signed or unsigned, and returns the result in one of three styles: wrapping (modulo 256), saturating (clamped to the lane's range) or halving (the exact 9-bit result shifted right by one). No carry or borrow ever passes from one lane into the next.

The wrapping operations also produce one greater-or-equal bit per lane, and the block keeps these four bits in a flag register. A separate select operation reads that stored flag field and builds its result byte by byte, taking each byte from the first operand or from the second. A typical sequence is a wrapping compare (a subtract whose value is discarded) followed by a select that merges two vectors lane by lane.

Operands, opcode and a valid strobe are sampled on a rising clock edge. The result register and the flag register both change on that same edge and hold their values while the strobe is low.

Top module: `simd8_alu`

## Requirements
- R1: Lanes are independent. Lane i occupies bits [8i+7:8i] and no carry or borrow crosses a lane boundary. For example, an unsigned wrapping add of 0x01FF01FF and 0x00010001 gives 0x01000100.
- R2: The opcode is {style[1:0], unsigned, subtract}. Style 00 is wrapping, and codes 0, 1, 2 and 3 are signed add, signed subtract, unsigned add and unsigned subtract. Each lane result is the low 8 bits of the exact sum or difference. It appears on `res_q` on the first rising edge at which `valid_i` is high.
- R3: On the same edge, a wrapping operation loads flag bit i of `flags_q` for lane i. For signed add and signed subtract the bit is 1 when the exact lane result is non-negative. For unsigned add it is the carry out. For unsigned subtract it is 1 when there is no borrow.
- R4: Style 01 saturates. Signed forms (code 4 add, code 5 subtract) clamp each lane to the range 0x80 to 0x7F, so 0x80 plus 0xFF gives 0x80 and 0x7F plus 0x02 gives 0x7F.
- R5: Unsigned saturating add (code 6) clamps an overflowing lane to 0xFF. Unsigned saturating subtract (code 7) clamps a negative lane to 0x00.
- R6: Style 10 halves. Codes 8 to 11 keep the exact 9-bit lane result and shift it right by one. The shift is arithmetic (rounding toward minus infinity) for the signed codes 8 and 9, so 0x8F minus 0x08 gives 0xC3. It is logical for the unsigned codes 10 and 11, so 7 plus 8 gives 7.
- R7: Select (code 12) gives byte i from operand A when flag bit i is 1, and from operand B otherwise. It uses the flags held before the edge. With flags 0b0010, A=0x33221100 and B=0x77665544, the result is 0x77661144.
- R8: Saturating, halving, select and reserved operations leave `flags_q` unchanged.
- R9: While `valid_i` is low, `res_q` and `flags_q` hold their values whatever the other inputs do.
- R10: A rising edge with `rst_n` low clears `res_q` to 0x00000000 and `flags_q` to 0b0000.
- R11: Reserved codes 13, 14 and 15 produce a result of 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation strobe; inputs are sampled when high |
| op_i | input | 4 | Opcode {style, unsigned, subtract}; 12 is select |
| a_i | input | 32 | Operand A, four byte lanes |
| b_i | input | 32 | Operand B, four byte lanes |
| res_q | output | 32 | Registered result |
| flags_q | output | 4 | Stored per-lane greater-or-equal flags |

## Verification
Every result, and every flag update, is due one clock edge after the strobed inputs. A select reads the flags as they stood before its own edge. The bench drives inputs on the falling edge. A behavioural reference model advances on each rising edge from the same inputs. On every falling edge the model's result and flags are compared with the outputs. Directed operations, drawn from the boundary cases in the requirements, are read back one falling edge after their strobe. A long run of mixed opcodes with the strobe toggling exercises the flag-hold and idle-hold rules cycle by cycle.

// File: rtl/simd8_pkg.sv
// Package simd8_pkg
// Opcode encoding shared by the packed byte unit. Bit layout is
// {style[1:0], unsigned, subtract}; style 11 holds select and reserved codes.
package simd8_pkg;

    typedef enum logic [1:0] {
        STY_WRAP = 2'b00,
        STY_SAT  = 2'b01,
        STY_HALF = 2'b10,
        STY_MISC = 2'b11
    } simd8_style_e;

    typedef enum logic [3:0] {
        OP_ADD_S_W = 4'd0,
        OP_SUB_S_W = 4'd1,
        OP_ADD_U_W = 4'd2,
        OP_SUB_U_W = 4'd3,
        OP_ADD_S_Q = 4'd4,
        OP_SUB_S_Q = 4'd5,
        OP_ADD_U_Q = 4'd6,
        OP_SUB_U_Q = 4'd7,
        OP_ADD_S_H = 4'd8,
        OP_SUB_S_H = 4'd9,
        OP_ADD_U_H = 4'd10,
        OP_SUB_U_H = 4'd11,
        OP_SELECT  = 4'd12,
        OP_RSVD_D  = 4'd13,
        OP_RSVD_E  = 4'd14,
        OP_RSVD_F  = 4'd15
    } simd8_op_e;

    // Style field of an opcode.
    function automatic simd8_style_e op_style(input simd8_op_e op);
        return simd8_style_e'(op[3:2]);
    endfunction

endpackage

// File: rtl/simd8_lane.sv
// Module simd8_lane
// Combinational datapath for one lane. Extends both operands by one bit
// (sign or zero, per opcode), forms the exact sum or difference, and derives
// wrapping, saturating, halving, select and flag outputs from it.
// Assumes: the caller registers the outputs; flag_i is the stored flag bit.
module simd8_lane
    import simd8_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  simd8_op_e         op_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic              flag_i,
    output logic [LANE_W-1:0] res_o,
    output logic              ge_o
);

    localparam int EXT_W = LANE_W + 1;

    logic             is_uns;
    logic             is_sub;
    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] exact;
    logic [LANE_W-1:0] pos_max;
    logic [LANE_W-1:0] neg_min;
    logic [LANE_W-1:0] sat_val;

    // Exact (LANE_W+1)-bit lane result.
    always_comb begin
        is_uns = op_i[1];
        is_sub = op_i[0];
        ext_a  = {(is_uns ? 1'b0 : a_i[LANE_W-1]), a_i};
        ext_b  = {(is_uns ? 1'b0 : b_i[LANE_W-1]), b_i};
        exact  = is_sub ? (ext_a - ext_b) : (ext_a + ext_b);
    end

    // Greater-or-equal flag: carry out for unsigned add, else non-negative.
    always_comb begin
        if (is_uns && !is_sub) ge_o = exact[EXT_W-1];
        else                   ge_o = ~exact[EXT_W-1];
    end

    // Clamped value for the saturating style.
    always_comb begin
        pos_max = {1'b0, {(LANE_W-1){1'b1}}};
        neg_min = {1'b1, {(LANE_W-1){1'b0}}};
        if (is_uns) begin
            if (exact[EXT_W-1]) sat_val = is_sub ? '0 : '1;
            else                sat_val = exact[LANE_W-1:0];
        end else begin
            if (exact[EXT_W-1] != exact[LANE_W-1])
                sat_val = exact[EXT_W-1] ? neg_min : pos_max;
            else
                sat_val = exact[LANE_W-1:0];
        end
    end

    // Result mux by style.
    always_comb begin
        unique case (op_style(op_i))
            STY_WRAP: res_o = exact[LANE_W-1:0];
            STY_SAT:  res_o = sat_val;
            STY_HALF: res_o = exact[EXT_W-1:1];
            default:  res_o = (op_i == OP_SELECT) ? (flag_i ? a_i : b_i) : '0;
        endcase
    end

endmodule

// File: rtl/simd8_flag_reg.sv
// Module simd8_flag_reg
// Holds the per-lane greater-or-equal flags. Loads all bits together when
// load_i is high; synchronous active-low reset to zero.
module simd8_flag_reg #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LANES-1:0] ge_i,
    output logic [LANES-1:0] flags_o
);

    // Flag storage with load enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_o <= '0;
        else if (load_i) flags_o <= ge_i;
    end

    // Flags change only on a load edge.
    p_flags_load_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_o));

endmodule

// File: rtl/simd8_alu.sv
// Module simd8_alu
// Top of the packed byte unit. Replicates one lane datapath per byte,
// registers the merged result on a valid strobe, and loads the flag
// register for wrapping opcodes only.
// Assumes: inputs are stable around the rising clock edge.
module simd8_alu
    import simd8_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic [3:0]              op_i,
    input  logic [LANES*LANE_W-1:0] a_i,
    input  logic [LANES*LANE_W-1:0] b_i,
    output logic [LANES*LANE_W-1:0] res_q,
    output logic [LANES-1:0]        flags_q
);

    localparam int WORD_W = LANES * LANE_W;

    simd8_op_e         op_e;
    logic [WORD_W-1:0] res_d;
    logic [LANES-1:0]  ge_d;
    logic              flag_load;

    assign op_e      = simd8_op_e'(op_i);
    assign flag_load = valid_i && (op_style(op_e) == STY_WRAP);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd8_lane #(.LANE_W(LANE_W)) u_lane (
            .op_i   (op_e),
            .a_i    (a_i[g*LANE_W +: LANE_W]),
            .b_i    (b_i[g*LANE_W +: LANE_W]),
            .flag_i (flags_q[g]),
            .res_o  (res_d[g*LANE_W +: LANE_W]),
            .ge_o   (ge_d[g])
        );

        // Selected byte comes from A or B as the stored flag dictated.
        p_select_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && op_e == OP_SELECT) |=>
            (res_q[g*LANE_W +: LANE_W] == ($past(flags_q[g]) ?
                $past(a_i[g*LANE_W +: LANE_W]) : $past(b_i[g*LANE_W +: LANE_W]))));

        // Unsigned saturating add never drops below operand A.
        p_usat_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && op_e == OP_ADD_U_Q) |=>
            (res_q[g*LANE_W +: LANE_W] >= $past(a_i[g*LANE_W +: LANE_W])));
    end

    simd8_flag_reg #(.LANES(LANES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (flag_load),
        .ge_i    (ge_d),
        .flags_o (flags_q)
    );

    // Result register, loaded on each valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (valid_i) res_q <= res_d;
    end

    // Idle cycles leave both outputs untouched.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_q) && $stable(flags_q)));

    // Non-wrapping operations keep the flags.
    p_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_style(op_e) != STY_WRAP) |=> $stable(flags_q));

    // Reserved codes yield zero.
    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > 4'd12) |=> (res_q == '0));

endmodule

// File: tb/tb_simd8_alu.sv
// Bench for simd8_alu: behavioural model stepped on every rising edge,
// compared with the outputs on every falling edge, plus directed checks.
module tb_simd8_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] a_i = 32'd0;
    logic [31:0] b_i = 32'd0;
    logic [31:0] res_q;
    logic [3:0]  flags_q;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R10";
    bit    seen_edge = 1'b0;

    logic [31:0] exp_res = 32'd0;
    logic [3:0]  exp_flags = 4'd0;

    simd8_alu dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_q(res_q), .flags_q(flags_q)
    );

    always #10 clk = ~clk;

    // Reference model: integer arithmetic per lane.
    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (!rst_n) begin
            exp_res   <= 32'd0;
            exp_flags <= 4'd0;
        end else if (valid_i) begin
            logic [31:0] r;
            logic [3:0]  f;
            r = 32'd0;
            f = exp_flags;
            for (int i = 0; i < 4; i++) begin
                int x, y, v, o;
                bit uns, sub;
                uns = op_i[1];
                sub = op_i[0];
                x = uns ? int'(a_i[8*i +: 8]) : int'($signed(a_i[8*i +: 8]));
                y = uns ? int'(b_i[8*i +: 8]) : int'($signed(b_i[8*i +: 8]));
                v = sub ? x - y : x + y;
                o = 0;
                if (op_i < 4) begin
                    o = v;
                    if (uns && !sub) f[i] = (v > 255);
                    else             f[i] = (v >= 0);
                end else if (op_i < 8) begin
                    if (uns) o = (v < 0) ? 0 : ((v > 255) ? 255 : v);
                    else     o = (v < -128) ? -128 : ((v > 127) ? 127 : v);
                end else if (op_i < 12) begin
                    o = v >>> 1;
                end else if (op_i == 12) begin
                    o = exp_flags[i] ? int'(a_i[8*i +: 8]) : int'(b_i[8*i +: 8]);
                end
                r[8*i +: 8] = o[7:0];
            end
            exp_res   <= r;
            exp_flags <= f;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (seen_edge) begin
            n_checks += 2;
            if (res_q !== exp_res) begin
                n_errors++;
                $display("FAIL %s cycle result: actual %h expected %h", cur_req, res_q, exp_res);
            end
            if (flags_q !== exp_flags) begin
                n_errors++;
                $display("FAIL %s cycle flags: actual %b expected %b", cur_req, flags_q, exp_flags);
            end
        end
    end

    task automatic lit(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s directed: actual %h expected %h", req, act, exp);
        end
    endtask

    // Strobe one operation; return at the falling edge after its result edge.
    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R10";
        lit("R10", res_q, 32'd0);
        lit("R10", {28'd0, flags_q}, 32'd0);
        rst_n = 1'b1;

        cur_req = "R3";
        run(4'd0, 32'h80808000, 32'h0);
        lit("R3", {28'd0, flags_q}, 32'h1);
        run(4'd0, 32'h80800080, 32'h0);
        lit("R3", {28'd0, flags_q}, 32'h2);

        cur_req = "R7";
        run(4'd12, 32'h33221100, 32'h77665544);
        lit("R7", res_q, 32'h77661144);
        lit("R8", {28'd0, flags_q}, 32'h2);

        cur_req = "R1";
        run(4'd2, 32'h01FF01FF, 32'h00010001);
        lit("R1", res_q, 32'h01000100);
        lit("R3", {28'd0, flags_q}, 32'h5);

        cur_req = "R2";
        run(4'd1, 32'h8F8B8783, 32'h08060402);
        lit("R2", res_q, 32'h87858381);
        lit("R3", {28'd0, flags_q}, 32'h0);
        run(4'd3, 32'h0F0B0703, 32'h08060402);
        lit("R2", res_q, 32'h07050301);
        lit("R3", {28'd0, flags_q}, 32'hF);

        cur_req = "R4";
        run(4'd4, 32'h8085837F, 32'hFF060402);
        lit("R4", res_q, 32'h808B877F);
        run(4'd5, 32'h808B8783, 32'h08060402);
        lit("R4", res_q, 32'h80858381);

        cur_req = "R5";
        run(4'd6, 32'hFF050301, 32'h08060402);
        lit("R5", res_q, 32'hFF0B0703);
        run(4'd7, 32'h080B0702, 32'h0F060408);
        lit("R5", res_q, 32'h00050300);
        lit("R8", {28'd0, flags_q}, 32'hF);

        cur_req = "R6";
        run(4'd9, 32'h8F8B8783, 32'h08060402);
        lit("R6", res_q, 32'hC3C2C1C0);
        run(4'd10, 32'h07050302, 32'h08060402);
        lit("R6", res_q, 32'h07050302);
        lit("R8", {28'd0, flags_q}, 32'hF);

        cur_req = "R11";
        run(4'd13, 32'h12345678, 32'h9ABCDEF0);
        lit("R11", res_q, 32'h0);

        cur_req = "R9";
        run(4'd2, 32'h10203040, 32'h01020304);
        @(negedge clk);
        op_i = 4'd1; a_i = 32'hFFFFFFFF; b_i = 32'h01010101;
        repeat (3) @(negedge clk);
        lit("R9", res_q, 32'h11223344);
        lit("R9", {28'd0, flags_q}, 32'h0);

        cur_req = "R2 R3 R7 R8 mixed";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            op_i    = 4'($urandom_range(0, 15));
            a_i     = $urandom;
            b_i     = $urandom;
            valid_i = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk);
        valid_i = 1'b0;
        repeat (2) @(negedge clk);

        cur_req = "R10";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        lit("R10", res_q, 32'd0);
        lit("R10", {28'd0, flags_q}, 32'd0);
        summary();
    end

endmodule